// File: doc/BRIEF.md
# Two-Pass Systematic Polar Encoder

This block turns a message into a systematic polar codeword of length N = 2^LOG_N. The caller presents an N-bit vector whose information positions carry the message bits. The block clears the frozen positions of that vector and multiplies it over GF(2) by the n-fold Kronecker power of the 2x2 lower-triangular kernel [[1,0],[1,1]]. It clears the frozen positions of that intermediate result and multiplies again by the same kernel power. The result carries every message bit unchanged at its own index, with parity in the frozen positions.

A single butterfly network of LOG_N XOR stages does both multiplications. The first pass runs in the cycle where `start` is accepted. The second runs in the following cycle, while the network's input is switched to the stored intermediate vector. The frozen set is a parameter mask: bit i set marks index i as frozen. A new message can be accepted every second cycle.

Top module: `polar_sys_encoder`

## Requirements
- R1: After reset, `cw_valid` is 0 and `codeword` is all zeros.
- R2: When `start` is accepted at a rising edge, `cw_valid` is 1 after exactly the second rising edge following it. `cw_valid` is high for one cycle only.
- R3: The codeword shown with `cw_valid` equals ((msg AND info) × G) AND info) × G over GF(2). Here info is the complement of FROZEN, G is the LOG_N-fold Kronecker power of [[1,0],[1,1]], and G[r][c] = 1 exactly when the bits of c are a subset of the bits of r.
- R4: At every information index (FROZEN bit 0), the codeword bit equals the message bit at that index.
- R5: Values at frozen indices of `msg` have no effect on the codeword.
- R6: `start` is ignored in the cycle right after an accepted start, while the second pass is running. It produces no extra `cw_valid`, and its message is never encoded.
- R7: `codeword` keeps its value in every cycle in which `cw_valid` is 0 after its last update.
- R8: A `start` in the cycle right after the ignored one is accepted. Codewords can be produced one every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to encode `msg` |
| msg | input | N | Message vector; only information indices are used |
| cw_valid | output | 1 | One-cycle pulse marking a new codeword |
| codeword | output | N | Systematic codeword, held until the next one |

## Verification
The bench builds the block with LOG_N = 3 (N = 8) and frozen indices 0, 1, 2 and 4, which leaves four information bits. With this size, all 16 messages can be enumerated and compared against a plain matrix product, with random junk placed in the frozen positions. Random messages then test the systematic property and the ignored frozen inputs. Directed sequences hold `start` high for two and three cycles, which covers the rule that a start is ignored during the second pass and the back-to-back acceptance rate.

// File: rtl/polar_sys_encoder.sv
module polar_sys_encoder #(
  parameter int LOG_N = 3,
  parameter logic [(1<<LOG_N)-1:0] FROZEN = 8'h17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [(1<<LOG_N)-1:0]   msg,
  output logic                    cw_valid,
  output logic [(1<<LOG_N)-1:0]   codeword
);
  localparam int N = 1 << LOG_N;
  localparam logic [N-1:0] INFO = ~FROZEN;

  logic         ph2;
  logic [N-1:0] mid_q;
  logic [N-1:0] bf_in;
  logic [N-1:0] bf_out;
  logic         take;

  assign take  = start && !ph2;
  assign bf_in = ph2 ? mid_q : (msg & INFO);

  for (genvar s = 0; s < LOG_N; s++) begin : stg
    logic [N-1:0] src;
    logic [N-1:0] dst;
    if (s == 0) begin : g_first
      assign src = bf_in;
    end else begin : g_next
      assign src = stg[s-1].dst;
    end
    for (genvar i = 0; i < N; i++) begin : bit_g
      if (((i >> s) & 1) == 0) begin : g_xor
        assign dst[i] = src[i] ^ src[i + (1 << s)];
      end else begin : g_pass
        assign dst[i] = src[i];
      end
    end
  end

  assign bf_out = stg[LOG_N-1].dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph2      <= 1'b0;
      mid_q    <= '0;
      codeword <= '0;
      cw_valid <= 1'b0;
    end else begin
      ph2      <= take;
      cw_valid <= ph2;
      if (take) mid_q <= bf_out & INFO;
      if (ph2)  codeword <= bf_out;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ph2) |=> ##1 cw_valid);  // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |=> !cw_valid);  // R2
  AST_INFO_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> ((codeword & INFO) == ($past(msg, 2) & INFO)));  // R4
  AST_CODEWORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_valid |-> $stable(codeword));  // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |=> !ph2);  // R6
endmodule

// File: tb/tb_polar_sys_encoder.sv
module tb_polar_sys_encoder;
  localparam int LOG_N = 3;
  localparam int N = 1 << LOG_N;
  localparam logic [N-1:0] FROZEN = 8'h17;
  localparam logic [N-1:0] INFO = ~FROZEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] msg = '0;
  logic cw_valid;
  logic [N-1:0] codeword;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  polar_sys_encoder #(.LOG_N(LOG_N), .FROZEN(FROZEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
    .cw_valid(cw_valid), .codeword(codeword));

  always #10 clk = ~clk;

  function automatic logic [N-1:0] kron_mul(input logic [N-1:0] u);
    logic [N-1:0] x = '0;
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++)
        if ((c & r) == c) x[c] = x[c] ^ u[r];
    return x;
  endfunction

  function automatic logic [N-1:0] ref_enc(input logic [N-1:0] m);
    return kron_mul(kron_mul(m & INFO) & INFO);
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic encode_one(input logic [N-1:0] m);
    @(negedge clk); start = 1'b1; msg = m;
    @(negedge clk); start = 1'b0; msg = $urandom;
    chk("R2 no early valid", {7'd0, cw_valid}, 8'd0);
    @(negedge clk);
    chk("R2 valid", {7'd0, cw_valid}, 8'd1);
    chk("R3 codeword", codeword, ref_enc(m));
    chk("R4 info bits", codeword & INFO, m & INFO);
    @(negedge clk);
    chk("R2 single pulse", {7'd0, cw_valid}, 8'd0);
  endtask

  initial begin
    logic [N-1:0] a, b, c, first;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 valid reset", {7'd0, cw_valid}, 8'd0);
    chk("R1 codeword reset", codeword, '0);
    rst_n = 1'b1;

    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] m = FROZEN & N'($urandom);
      m[3] = k[0]; m[5] = k[1]; m[6] = k[2]; m[7] = k[3];
      encode_one(m);
    end
    for (int k = 0; k < 30; k++) encode_one(N'($urandom));

    a = N'($urandom);
    encode_one(a & INFO);
    first = codeword;
    encode_one(a | FROZEN);
    chk("R5 frozen inputs ignored", codeword, first);

    a = 8'hE8; b = 8'h28;
    @(negedge clk); start = 1'b1; msg = a;
    @(negedge clk); msg = b;
    @(negedge clk); start = 1'b0;
    chk("R6 first result", codeword, ref_enc(a));
    @(negedge clk);
    chk("R6 no extra valid", {7'd0, cw_valid}, 8'd0);
    chk("R7 codeword held", codeword, ref_enc(a));
    @(negedge clk);
    chk("R6 still idle", {7'd0, cw_valid}, 8'd0);

    a = 8'h08; b = 8'h60; c = 8'hA8;
    @(negedge clk); start = 1'b1; msg = a;
    @(negedge clk); msg = b;
    @(negedge clk); msg = c;
    chk("R8 first valid", {7'd0, cw_valid}, 8'd1);
    chk("R8 first codeword", codeword, ref_enc(a));
    @(negedge clk); start = 1'b0;
    chk("R8 gap", {7'd0, cw_valid}, 8'd0);
    @(negedge clk);
    chk("R8 second valid", {7'd0, cw_valid}, 8'd1);
    chk("R8 second codeword", codeword, ref_enc(c));
    repeat (3) @(negedge clk);
    chk("R7 held after pulse", codeword, ref_enc(c));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule